// File: doc/BRIEF.md
# Sampling Converter Start and Serial Readout Controller

This block sits on the host side of a 12-bit sampling converter that returns its result over a simple clocked serial line. When asked for a sample, it pulls an active-low start line down to launch a conversion. It then holds the serial clock low for a fixed wait, derived from the system clock frequency and rounded up so that the converter's 3.3 µs conversion time is always covered. After the wait it produces sixteen serial clock pulses and captures the data line as each pulse falls.

The converter sends a 16-bit frame: four zero bits first, then the 12-bit result with the most significant bit first. The controller keeps the last twelve bits as the result and sets an error flag when any of the four leading bits is not zero. Result and flag come out together with a one-cycle valid strobe.

The burst can be split into two bytes by an idle-low gap after the eighth pulse. A guard interval of at least 100 ns, in system cycles, is kept between the last serial clock fall and the next start edge. If a request arrives while a read or guard interval is in progress, it is remembered and served as soon as the guard interval ends. Several such requests count as one.

Top module: `adc_readout_ctrl`

## Requirements
- R1: During and right after reset, `start_n` is 1, `ser_clk` is 0, `result_valid` is 0, `sample_data` is 0 and `frame_err` is 0.
- R2: A request seen in idle drives `start_n` low for exactly `START_LOW_CYC` cycles and then high again. `ser_clk` is 0 in the cycle `start_n` falls and while `start_n` is low.
- R3: The first rising edge of `ser_clk` comes exactly ceil(`CONV_NS`*`CLK_MHZ`/1000) cycles after `start_n` falls, and `ser_clk` stays 0 for that whole window.
- R4: Each frame has exactly 16 `ser_clk` pulses. Each pulse is high for `HALF_CYC` cycles, and the low time between two pulses is `HALF_CYC` cycles (except as in R8).
- R5: `ser_din` is captured at each falling edge of `ser_clk`. The first capture is frame bit 15 and the last is bit 0. `sample_data` is frame bits 11..0, with bit 11 from the fifth capture.
- R6: `frame_err` is 1 exactly when any of frame bits 15..12 (the first four captures) is 1. It is updated together with `sample_data`.
- R7: `result_valid` is a one-cycle pulse, `START_LOW`-independent, that comes exactly CONV + 32*`HALF_CYC` + `BYTE_GAP_CYC` cycles after `start_n` falls. `sample_data` and `frame_err` hold their values until the next pulse.
- R8: When `BYTE_GAP_CYC` > 0, the low time between the eighth and ninth pulse is `HALF_CYC` + `BYTE_GAP_CYC` cycles.
- R9: At least ceil(`GUARD_NS`*`CLK_MHZ`/1000) cycles pass between the last `ser_clk` fall of a frame and the next fall of `start_n`.
- R10: A request that arrives while a conversion, read or guard interval is in progress is kept. `start_n` then falls exactly guard+1 cycles after the `result_valid` pulse of the current frame.
- R11: Several requests during one busy interval cause only one extra conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_req | input | 1 | Request for one conversion and readout |
| ser_din | input | 1 | Serial data from the converter |
| start_n | output | 1 | Conversion start line, active low; the falling edge starts a conversion |
| ser_clk | output | 1 | Serial clock to the converter |
| sample_data | output | 12 | Last 12-bit conversion result |
| result_valid | output | 1 | One-cycle strobe when a new result is presented |
| frame_err | output | 1 | Leading bits of the last frame were not all zero |

## Verification
The hardest case to reach is a request that arrives while the block is busy. It has to be remembered across the conversion wait or the guard interval, and several such requests have to merge into one. The stimulus reaches this by firing requests at set points inside a conversion and just after a valid strobe. It then measures the start edge against the strobe and counts conversions over a long quiet interval. A behavioural converter in the bench shifts out frames built arithmetically from the frame index, including walking ones and nonzero leading bits, so that each capture position and the error flag are exercised.

// File: rtl/adc_rd_pkg.sv
// Shared types and helpers for the converter readout controller.
// Assumes: time values are given in whole nanoseconds and the clock in MHz.
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_GAP,
        ST_GUARD
    } rd_state_e;

    // Cycles that cover a duration, rounded up.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/rd_timer.sv
// Down-counting interval timer.
// Assumes: a load of N-1 gives an interval of N cycles, ending in the cycle where done is high.
module rd_timer #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         done
);
    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/rd_frame_shift.sv
// Serial frame capture: shifts in one bit per capture strobe, MSB first, and
// publishes the data field together with a leading-bit check.
// Assumes: clear comes before the first capture of every frame.
module rd_frame_shift #(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned DATA_BITS  = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear,
    input  logic                              capture,
    input  logic                              din,
    input  logic                              publish,
    output logic [$clog2(FRAME_BITS+1)-1:0]   bit_cnt,
    output logic [DATA_BITS-1:0]              data,
    output logic                              valid,
    output logic                              lead_err
);
    localparam int unsigned LEAD_BITS = FRAME_BITS - DATA_BITS;

    logic [FRAME_BITS-1:0] shreg;

    // Shift in one bit per capture and count the captured bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
        end else if (capture) begin
            shreg   <= {shreg[FRAME_BITS-2:0], din};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Present data and leading-bit check once per completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data     <= '0;
            lead_err <= 1'b0;
            valid    <= 1'b0;
        end else begin
            valid <= publish;
            if (publish) begin
                data     <= shreg[DATA_BITS-1:0];
                lead_err <= |shreg[FRAME_BITS-1 -: LEAD_BITS];
            end
        end
    end
endmodule

// File: rtl/adc_readout_ctrl.sv
// Converter start and serial readout sequencer.
// Starts a conversion with a low pulse on start_n, keeps ser_clk low for the
// conversion wait, reads a 16-bit frame with 16 ser_clk pulses (optionally split
// in two bytes), then holds a guard interval before any new start edge.
// Assumes: START_LOW_CYC < conversion cycles, HALF_CYC >= 1, converter updates
// data on falling ser_clk edges and holds it briefly after.
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 250,
    parameter int unsigned CONV_NS       = 3300,
    parameter int unsigned GUARD_NS      = 100,
    parameter int unsigned HALF_CYC      = 4,
    parameter int unsigned START_LOW_CYC = 4,
    parameter int unsigned BYTE_GAP_CYC  = 0,
    parameter int unsigned FRAME_BITS    = 16,
    parameter int unsigned DATA_BITS     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_req,
    input  logic                 ser_din,
    output logic                 start_n,
    output logic                 ser_clk,
    output logic [DATA_BITS-1:0] sample_data,
    output logic                 result_valid,
    output logic                 frame_err
);
    localparam int unsigned CONV_CYC  = ns_to_cycles(CONV_NS, CLK_MHZ);
    localparam int unsigned GUARD_RAW = ns_to_cycles(GUARD_NS, CLK_MHZ);
    localparam int unsigned GUARD_CYC = (GUARD_RAW == 0) ? 1 : GUARD_RAW;
    localparam int unsigned GAP_EFF   = (BYTE_GAP_CYC == 0) ? 1 : BYTE_GAP_CYC;
    localparam int unsigned BYTE_BITS = FRAME_BITS / 2;
    localparam int unsigned MAX_A     = (CONV_CYC > GUARD_CYC) ? CONV_CYC : GUARD_CYC;
    localparam int unsigned MAX_B     = (HALF_CYC > GAP_EFF) ? HALF_CYC : GAP_EFF;
    localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW        = $clog2(MAX_CYC + 1);
    localparam int unsigned CW        = $clog2(FRAME_BITS + 1);

    rd_state_e         state_q, state_d;
    logic              pend_q;
    logic              t_load, t_done;
    logic [TW-1:0]     t_val, t_cnt;
    logic              fr_clear, fr_cap, fr_pub;
    logic [CW-1:0]     bit_cnt;

    rd_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .cnt      (t_cnt),
        .done     (t_done)
    );

    rd_frame_shift #(.FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (fr_clear),
        .capture  (fr_cap),
        .din      (ser_din),
        .publish  (fr_pub),
        .bit_cnt  (bit_cnt),
        .data     (sample_data),
        .valid    (result_valid),
        .lead_err (frame_err)
    );

    // Sequence: idle -> conversion wait -> clock pulses (with byte gap) -> guard.
    always_comb begin
        state_d  = state_q;
        t_load   = 1'b0;
        t_val    = '0;
        fr_clear = 1'b0;
        fr_cap   = 1'b0;
        fr_pub   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (pend_q || sample_req) begin
                state_d  = ST_CONV;
                t_load   = 1'b1;
                t_val    = TW'(CONV_CYC - 1);
                fr_clear = 1'b1;
            end
            ST_CONV: if (t_done) begin
                state_d = ST_CLK_HI;
                t_load  = 1'b1;
                t_val   = TW'(HALF_CYC - 1);
            end
            ST_CLK_HI: if (t_done) begin
                state_d = ST_CLK_LO;
                t_load  = 1'b1;
                t_val   = TW'(HALF_CYC - 1);
                fr_cap  = 1'b1;
            end
            ST_CLK_LO: if (t_done) begin
                t_load = 1'b1;
                if (bit_cnt == CW'(FRAME_BITS)) begin
                    state_d = ST_GUARD;
                    t_val   = TW'(GUARD_CYC - 1);
                    fr_pub  = 1'b1;
                end else if (BYTE_GAP_CYC != 0 && bit_cnt == CW'(BYTE_BITS)) begin
                    state_d = ST_GAP;
                    t_val   = TW'(GAP_EFF - 1);
                end else begin
                    state_d = ST_CLK_HI;
                    t_val   = TW'(HALF_CYC - 1);
                end
            end
            ST_GAP: if (t_done) begin
                state_d = ST_CLK_HI;
                t_load  = 1'b1;
                t_val   = TW'(HALF_CYC - 1);
            end
            ST_GUARD: if (t_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remember one request that arrives while busy; cleared when a conversion starts.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (fr_clear) pend_q <= 1'b0;
        else if (sample_req) pend_q <= 1'b1;
    end

    // Start line is low for the first START_LOW_CYC cycles of the wait.
    assign start_n = !((state_q == ST_CONV) && (t_cnt > TW'(CONV_CYC - 1 - START_LOW_CYC)));
    assign ser_clk = (state_q == ST_CLK_HI);
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
// Protocol checker for adc_readout_ctrl, bound to every instance.
// Assumes: parameters match the bound instance.
module adc_readout_ctrl_chk #(
    parameter int unsigned CONV_CYC  = 825,
    parameter int unsigned GUARD_CYC = 25,
    parameter int unsigned DATA_BITS = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_n,
    input logic                 ser_clk,
    input logic [DATA_BITS-1:0] sample_data,
    input logic                 result_valid,
    input logic                 frame_err
);
    localparam int unsigned WW = $clog2(CONV_CYC + GUARD_CYC + 2);

    logic          start_prev, clk_prev;
    logic [WW-1:0] conv_win, since_fall;
    logic          fall_now;

    assign fall_now = start_prev && !start_n;

    // Track the conversion window and the time since the last serial clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_prev <= 1'b1;
            clk_prev   <= 1'b0;
            conv_win   <= '0;
            since_fall <= WW'(GUARD_CYC);
        end else begin
            start_prev <= start_n;
            clk_prev   <= ser_clk;
            if (fall_now)
                conv_win <= WW'(CONV_CYC - 1);
            else if (conv_win != '0)
                conv_win <= conv_win - 1'b1;
            if (clk_prev && !ser_clk)
                since_fall <= '0;
            else if (since_fall < WW'(GUARD_CYC))
                since_fall <= since_fall + 1'b1;
        end
    end

    AST_CLK_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        fall_now |-> !ser_clk); // R2
    AST_CLK_LOW_WHILE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |-> !ser_clk); // R2
    AST_CLK_LOW_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_win != '0) |-> !ser_clk); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(sample_data) && $stable(frame_err))); // R7
    AST_GUARD_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        fall_now |-> (since_fall >= WW'(GUARD_CYC))); // R9
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(
    .CONV_CYC  (CONV_CYC),
    .GUARD_CYC (GUARD_CYC),
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_n      (start_n),
    .ser_clk      (ser_clk),
    .sample_data  (sample_data),
    .result_valid (result_valid),
    .frame_err    (frame_err)
);

// File: tb/tb_adc_readout_ctrl.sv
// Bench: behavioural converter plus protocol monitor and request sequences.
module tb_adc_readout_ctrl;
    localparam int CLK_MHZ = 250;
    localparam int CONV_NS = 3300;
    localparam int GRD_NS  = 100;
    localparam int HALF    = 2;
    localparam int LOWC    = 4;
    localparam int GAP     = 5;
    localparam int CONV_E  = (CONV_NS * CLK_MHZ + 999) / 1000;
    localparam int GUARD_E = (GRD_NS * CLK_MHZ + 999) / 1000;
    localparam int LAT_E   = CONV_E + 32 * HALF + GAP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_req = 1'b0;
    logic        ser_din = 1'b0;
    logic        start_n, ser_clk, result_valid, frame_err;
    logic [11:0] sample_data;

    int n_chk = 0, n_err = 0, cyc = 0;
    int n_start = 0, n_done = 0;
    int fall_t = 0, rise_t = 0, last_sfall = 0, last_valid = 0, pulses = 0;
    bit have_read = 0, expect_pend = 0, finished = 0;
    logic        prev_conv = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0;
    logic [15:0] cur_frame = '0;
    logic [11:0] last_code = '0;

    adc_readout_ctrl #(
        .CLK_MHZ(CLK_MHZ), .CONV_NS(CONV_NS), .GUARD_NS(GRD_NS),
        .HALF_CYC(HALF), .START_LOW_CYC(LOWC), .BYTE_GAP_CYC(GAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .ser_din(ser_din),
        .start_n(start_n), .ser_clk(ser_clk), .sample_data(sample_data),
        .result_valid(result_valid), .frame_err(frame_err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [11:0] code_of(input int n);
        if (n < 12)  return 12'(1 << n);
        if (n == 12) return 12'h000;
        if (n == 13) return 12'hFFF;
        return 12'((n * 2741 + 77) % 4096);
    endfunction

    function automatic logic [3:0] lead_of(input int n);
        return (n % 5 == 2) ? 4'(((n * 3) % 15) + 1) : 4'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model and protocol monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_conv && !start_n) begin
                chk(ser_clk == 1'b0, "R2 clk low at start", int'(ser_clk), 0);
                if (have_read)
                    chk(cyc - last_sfall >= GUARD_E, "R9 guard", cyc - last_sfall, GUARD_E);
                if (expect_pend) begin
                    chk(cyc - last_valid == GUARD_E + 1, "R10 held start", cyc - last_valid, GUARD_E + 1);
                    expect_pend = 0;
                end
                if (n_done > 0)
                    chk(sample_data == last_code, "R7 hold", int'(sample_data), int'(last_code));
                fall_t    = cyc;
                pulses    = 0;
                cur_frame = {lead_of(n_start), code_of(n_start)};
                ser_din   = cur_frame[15];
                n_start++;
            end
            if (!prev_conv && start_n)
                chk(cyc - fall_t == LOWC, "R2 start width", cyc - fall_t, LOWC);
            if (!prev_sclk && ser_clk) begin
                if (pulses == 0)
                    chk(cyc - fall_t == CONV_E, "R3 conv wait", cyc - fall_t, CONV_E);
                else if (pulses == 8)
                    chk(cyc - last_sfall == HALF + GAP, "R8 byte gap", cyc - last_sfall, HALF + GAP);
                else
                    chk(cyc - last_sfall == HALF, "R4 low time", cyc - last_sfall, HALF);
                rise_t = cyc;
            end
            if (prev_sclk && !ser_clk) begin
                chk(cyc - rise_t == HALF, "R4 high time", cyc - rise_t, HALF);
                pulses++;
                last_sfall = cyc;
                have_read  = 1;
                ser_din    = (pulses < 16) ? cur_frame[15 - pulses] : 1'b0;
            end
            if (!prev_valid && result_valid) begin
                chk(pulses == 16, "R4 pulse count", pulses, 16);
                chk(cyc - fall_t == LAT_E, "R7 latency", cyc - fall_t, LAT_E);
                chk(sample_data == cur_frame[11:0], "R5 data", int'(sample_data), int'(cur_frame[11:0]));
                chk(frame_err == (cur_frame[15:12] != 4'h0), "R6 lead check",
                    int'(frame_err), int'(cur_frame[15:12] != 4'h0));
                last_valid = cyc;
                last_code  = cur_frame[11:0];
                n_done++;
            end
            if (prev_valid && result_valid)
                chk(1'b0, "R7 strobe width", 2, 1);
            prev_conv  = start_n;
            prev_sclk  = ser_clk;
            prev_valid = result_valid;
        end
    end

    task automatic pulse_req();
        @(negedge clk) sample_req = 1'b1;
        @(negedge clk) sample_req = 1'b0;
    endtask

    task automatic check_idle_outputs();
        chk(start_n == 1'b1, "R1 start_n", int'(start_n), 1);
        chk(ser_clk == 1'b0, "R1 ser_clk", int'(ser_clk), 0);
        chk(result_valid == 1'b0, "R1 valid", int'(result_valid), 0);
        chk(sample_data == 12'h0, "R1 data", int'(sample_data), 0);
        chk(frame_err == 1'b0, "R1 err", int'(frame_err), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check_idle_outputs();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle_outputs();
        // Sweep: walking ones, extremes, arithmetic codes, some nonzero leads.
        for (int f = 0; f < 30; f++) begin
            pulse_req();
            wait (n_done == f + 1);
            repeat (3) @(negedge clk);
        end
        // R10/R11: three requests inside one conversion give one extra frame.
        pulse_req();
        repeat (100) @(negedge clk);
        pulse_req();
        expect_pend = 1;
        repeat (50) @(negedge clk);
        pulse_req();
        repeat (400) @(negedge clk);
        pulse_req();
        wait (n_done == 32);
        repeat (2000) @(negedge clk);
        chk(n_start == 32, "R11 merged requests", n_start, 32);
        // R10: request during the guard interval.
        pulse_req();
        wait (n_done == 33);
        repeat (3) @(negedge clk);
        pulse_req();
        expect_pend = 1;
        wait (n_done == 34);
        repeat (50) @(negedge clk);
        chk(n_start == 34, "R10 one start per request", n_start, 34);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_done, 34);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule